// File: doc/BRIEF.md
# Clock-Synchronous Serial Byte Receiver

This block receives bytes over a two-wire clock-synchronous link made of a serial clock and a serial data line. In master mode it generates the serial clock itself from the system clock. The rate comes from a 4-bit select code. The clock idles high and starts as soon as both the enable and master controls are set. In slave mode the clock arrives from the far end. It passes through a synchronizer, and its rising edges are found in the system clock domain.

A data bit is captured on each rising serial-clock edge, least significant bit first. After eight bits the assembled byte is copied to a holding register and a full flag is raised. Reading the holding register drops the flag. If the flag is still set when the next byte completes, an overrun flag is set and the older byte stays in place. In master mode a stop request lets the byte in progress finish and then parks the clock high. Control and status are plain level and strobe ports.

Top module: `serial_sync_rx`

## Requirements
- R1: After reset `rx_full` = 0, `ovr_flag` = 0, `sclk_out` = 1 and `sclk_oe` = 0.
- R2: With `en` = 1 and `master` = 1, `sclk_oe` = 1 and `sclk_out` toggles every N/2 system clocks. N is 4 << `clk_sel` for `clk_sel` 0 to 7, and N is 512 for any `clk_sel` of 8 or above. The first edge after starting is a falling edge.
- R3: Each data bit is sampled on a rising serial-clock edge. Bit 0 is received first. After the 8th bit the byte appears on `rx_data` and `rx_full` becomes 1.
- R4: A one-cycle `rd` strobe clears `rx_full`.
- R5: If `rx_full` is 1 at the 8th rising edge of the next byte, `ovr_flag` becomes 1 and `rx_data` keeps the older byte.
- R6: `ovr_flag` is cleared only by an `ovr_clr` strobe. Reading with `rd` leaves it set.
- R7: While `stop_req` = 1 in master mode, the byte in progress completes. After that `sclk_out` stays high with no further edges.
- R8: With `master` = 0, `sclk_oe` = 0. Bytes are received using `sclk_in` as the clock, and `sclk_in` passes through a two-stage synchronizer.
- R9: With `en` = 0 the serial clock stays high and no bits are taken. Bits already collected of an unfinished byte are discarded, so the next byte after re-enabling is assembled correctly.
- R10: In master mode without a stop request, bytes follow one another with no gap: the falling-edge spacing across a byte boundary is still N. Reading each byte in time avoids overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Transfer enable |
| master | input | 1 | 1: drive the serial clock, 0: take it from `sclk_in` |
| clk_sel | input | 4 | Serial clock rate select code |
| stop_req | input | 1 | Stop the clock after the current byte (master) |
| rd | input | 1 | Read strobe for the holding register |
| ovr_clr | input | 1 | Strobe that clears the overrun flag |
| sclk_in | input | 1 | Serial clock input in slave mode |
| sda_in | input | 1 | Serial data input |
| sclk_out | output | 1 | Serial clock value driven in master mode |
| sclk_oe | output | 1 | Serial clock output enable |
| rx_data | output | 8 | Holding register contents |
| rx_full | output | 1 | Holding register full flag |
| ovr_flag | output | 1 | Overrun flag |

## Verification
A wrong bit counter or shift direction shows up on `rx_data` as a rotated or bit-reversed byte at the very next `rx_full` rise. A wrong divider or halt state shows up within one serial period, as a changed falling-edge spacing or as an extra edge after a stop. A full flag that is not cleared properly turns into a false `ovr_flag` one byte later. The bench therefore compares every received byte, times the clock edges, and counts edges after each stop.

// File: rtl/ssrx_pkg.sv
package ssrx_pkg;
   // Log2 of the system-clock divide ratio for a select code, clipped at max_log.
   function automatic int unsigned div_log(input int unsigned sel,
                                           input int unsigned min_log,
                                           input int unsigned max_log);
      int unsigned lg;
      lg = min_log + sel;
      if (lg > max_log) lg = max_log;
      return lg;
   endfunction
endpackage

// File: rtl/ssrx_sync.sv
module ssrx_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q,
   output logic         rise0
);
   logic [W-1:0] stg [STAGES];
   logic         prev0;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[0] <= '1;
               else        stg[0] <= d;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) stg[i] <= '1;
               else        stg[i] <= stg[i-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev0 <= 1'b1;
      else        prev0 <= stg[STAGES-1][0];

   assign q     = stg[STAGES-1];
   assign rise0 = stg[STAGES-1][0] & ~prev0;
endmodule

// File: rtl/ssrx_clkgen.sv
module ssrx_clkgen
   import ssrx_pkg::*;
#(
   parameter int SEL_W   = 4,
   parameter int MIN_LOG = 2,
   parameter int MAX_LOG = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             master,
   input  logic [SEL_W-1:0] sel,
   input  logic             stop_req,
   input  logic             byte_done,
   output logic             sclk,
   output logic             rise
);
   localparam int CW = MAX_LOG;

   logic [CW-1:0] cnt, half_m1;
   logic          sclk_q, halted, run, term;
   int unsigned   lg;

   always_comb begin
      lg      = div_log(int'(sel), MIN_LOG, MAX_LOG);
      half_m1 = CW'((32'd1 << (lg - 1)) - 32'd1);
   end

   assign run  = en & master & ~halted;
   assign term = (cnt == half_m1);
   assign rise = run & term & ~sclk_q;
   assign sclk = sclk_q;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         cnt    <= '0;
         sclk_q <= 1'b1;
      end else if (!run) begin
         cnt    <= '0;
         sclk_q <= 1'b1;
      end else if (term) begin
         cnt    <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         cnt    <= cnt + 1'b1;
      end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                          halted <= 1'b0;
      else if (!stop_req || !en || !master) halted <= 1'b0;
      else if (byte_done)                  halted <= 1'b1;

   // R9
   idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> sclk_q);
   // R7
   halt_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(halted) |-> sclk_q);
endmodule

// File: rtl/ssrx_rxcore.sv
module ssrx_rxcore #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              rise,
   input  logic              bit_in,
   input  logic              rd,
   input  logic              ovr_clr,
   output logic [DATA_W-1:0] data,
   output logic              full,
   output logic              ovr,
   output logic              done
);
   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] shreg, nxt;
   logic [CNT_W-1:0]  bitcnt;
   logic              full_eff;

   assign nxt      = {bit_in, shreg[DATA_W-1:1]};
   assign done     = en & rise & (bitcnt == LAST);
   assign full_eff = full & ~rd;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         shreg  <= '0;
         bitcnt <= '0;
      end else if (!en) begin
         bitcnt <= '0;
      end else if (rise) begin
         shreg  <= nxt;
         bitcnt <= (bitcnt == LAST) ? '0 : bitcnt + 1'b1;
      end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         data <= '0;
         full <= 1'b0;
      end else if (done && !full_eff) begin
         data <= nxt;
         full <= 1'b1;
      end else if (rd) begin
         full <= 1'b0;
      end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                ovr <= 1'b0;
      else if (done && full_eff) ovr <= 1'b1;
      else if (ovr_clr)          ovr <= 1'b0;

   // R3
   full_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full) |-> $past(rise));
   // R5
   ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr) |-> $stable(data));
   // R4
   rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !done) |=> !full);
endmodule

// File: rtl/serial_sync_rx.sv
module serial_sync_rx #(
   parameter int DATA_W      = 8,
   parameter int SEL_W       = 4,
   parameter int MIN_LOG     = 2,
   parameter int MAX_LOG     = 9,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              master,
   input  logic [SEL_W-1:0]  clk_sel,
   input  logic              stop_req,
   input  logic              rd,
   input  logic              ovr_clr,
   input  logic              sclk_in,
   input  logic              sda_in,
   output logic              sclk_out,
   output logic              sclk_oe,
   output logic [DATA_W-1:0] rx_data,
   output logic              rx_full,
   output logic              ovr_flag
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MIN_LOG < 1 || MAX_LOG < MIN_LOG) begin : g_bad_div
         $error("divider log range is invalid");
      end
   endgenerate

   logic       m_rise, s_rise, rise, bit_in, byte_done;
   logic [1:0] s_q;

   ssrx_clkgen #(.SEL_W(SEL_W), .MIN_LOG(MIN_LOG), .MAX_LOG(MAX_LOG)) u_clk (
      .clk(clk), .rst_n(rst_n), .en(en), .master(master), .sel(clk_sel),
      .stop_req(stop_req), .byte_done(byte_done), .sclk(sclk_out), .rise(m_rise)
   );

   ssrx_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({sda_in, sclk_in}), .q(s_q), .rise0(s_rise)
   );

   assign rise   = master ? m_rise : s_rise;
   assign bit_in = master ? sda_in : s_q[1];

   ssrx_rxcore #(.DATA_W(DATA_W)) u_core (
      .clk(clk), .rst_n(rst_n), .en(en), .rise(rise), .bit_in(bit_in),
      .rd(rd), .ovr_clr(ovr_clr), .data(rx_data), .full(rx_full),
      .ovr(ovr_flag), .done(byte_done)
   );

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sclk_oe <= 1'b0;
      else        sclk_oe <= en & master;

   // R8
   slave_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !master |=> !sclk_oe);
endmodule

// File: tb/serial_sync_rx_test.sv
module serial_sync_rx_test;
   logic       clk = 0, rst_n = 0;
   logic       en = 0, master = 0, stop_req = 0, rd = 0, ovr_clr = 0;
   logic [3:0] clk_sel = 0;
   logic       sclk_in = 1, sda_in = 0;
   logic       sclk_out, sclk_oe, rx_full, ovr_flag;
   logic [7:0] rx_data;

   int  n_run = 0, n_fail = 0, fall_cnt = 0;
   time fall_t [16];

   always #10 clk = ~clk;

   serial_sync_rx uut (.*);

   always @(negedge sclk_out) fall_cnt++;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic drive_bits(input logic [15:0] bits, input int nb, input int stop_at);
      for (int i = 0; i < nb; i++) begin
         @(negedge sclk_out);
         fall_t[i] = $time;
         #1 sda_in = bits[i];
         if (i == stop_at) stop_req = 1;
      end
   endtask

   task automatic wait_full(input int lim);
      for (int i = 0; i < lim; i++) begin
         @(negedge clk);
         if (rx_full) break;
      end
   endtask

   task automatic pulse_rd();
      @(negedge clk) rd = 1;
      @(negedge clk) rd = 0;
   endtask

   task automatic idle();
      @(negedge clk);
      en = 0; master = 0; stop_req = 0;
      repeat (4) @(negedge clk);
   endtask

   // {sel, data, divide ratio}
   localparam logic [27:0] VEC [7] = '{
      {4'd0,  8'hA5, 16'd4},  {4'd1, 8'h3C, 16'd8},   {4'd3, 8'h81, 16'd32},
      {4'd7,  8'h5A, 16'd512}, {4'd12, 8'hE7, 16'd512}, {4'd2, 8'h00, 16'd16},
      {4'd5,  8'hFF, 16'd128}
   };

   initial begin
      repeat (180000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      int f0, n;
      logic [7:0] d;
      repeat (3) @(negedge clk);
      // R1
      chk(rx_full == 0 && ovr_flag == 0, "R1 flags", {rx_full, ovr_flag}, 0);
      chk(sclk_out == 1 && sclk_oe == 0, "R1 clock", {sclk_out, sclk_oe}, 2);
      rst_n = 1;
      repeat (2) @(negedge clk);

      // R2, R3, R7: table walk, one byte per setting with stop requested
      for (int v = 0; v < 7; v++) begin
         d = VEC[v][23:16]; n = int'(VEC[v][15:0]);
         @(negedge clk);
         clk_sel = VEC[v][27:24]; stop_req = 1; master = 1; en = 1;
         f0 = fall_cnt;
         drive_bits({8'h00, d}, 8, -1);
         wait_full(2 * n);
         chk(rx_full == 1, "R3 full", rx_full, 1);
         chk(rx_data == d, "R3 data", rx_data, d);
         chk(int'((fall_t[1] - fall_t[0]) / 20) == n, "R2 period",
             int'((fall_t[1] - fall_t[0]) / 20), n);
         chk(sclk_oe == 1, "R2 oe", sclk_oe, 1);
         repeat (3 * n) @(negedge clk);
         chk(fall_cnt - f0 == 8 && sclk_out == 1, "R7 halt", fall_cnt - f0, 8);
         pulse_rd();
         chk(rx_full == 0, "R4 read clears", rx_full, 0);
         idle();
      end

      // R10: back-to-back bytes, each read in time
      @(negedge clk);
      clk_sel = 0; master = 1; en = 1;
      fork
         drive_bits(16'h7E_C3, 16, 9);
         begin wait_full(200); pulse_rd(); end
      join
      wait_full(200);
      chk(rx_data == 8'h7E, "R10 second byte", rx_data, 8'h7E);
      chk(ovr_flag == 0, "R10 no overrun", ovr_flag, 0);
      chk(int'((fall_t[8] - fall_t[7]) / 20) == 4, "R10 no gap",
          int'((fall_t[8] - fall_t[7]) / 20), 4);
      pulse_rd();
      idle();

      // R5, R6: second byte arrives while the first is unread
      @(negedge clk);
      clk_sel = 0; master = 1; en = 1;
      drive_bits(16'h55_96, 16, 9);
      repeat (20) @(negedge clk);
      chk(ovr_flag == 1, "R5 overrun set", ovr_flag, 1);
      chk(rx_data == 8'h96, "R5 older byte kept", rx_data, 8'h96);
      pulse_rd();
      chk(rx_full == 0 && ovr_flag == 1, "R6 read keeps overrun", ovr_flag, 1);
      @(negedge clk) ovr_clr = 1;
      @(negedge clk) ovr_clr = 0;
      chk(ovr_flag == 0, "R6 clear strobe", ovr_flag, 0);
      idle();

      // R8: slave mode
      @(negedge clk);
      en = 1; master = 0;
      for (int i = 0; i < 8; i++) begin
         sclk_in = 0; sda_in = 8'hB4 >> i;
         repeat (4) @(negedge clk);
         sclk_in = 1;
         repeat (4) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      chk(rx_data == 8'hB4 && rx_full == 1, "R8 slave byte", rx_data, 8'hB4);
      chk(sclk_oe == 0 && sclk_out == 1, "R8 released", {sclk_oe, sclk_out}, 1);
      pulse_rd();
      idle();

      // R9: disable mid-byte, then a clean byte
      @(negedge clk);
      clk_sel = 0; master = 1; en = 1;
      drive_bits(16'h0007, 3, -1);
      @(negedge clk) en = 0;
      f0 = fall_cnt;
      repeat (12) @(negedge clk);
      chk(sclk_out == 1 && fall_cnt == f0, "R9 clock idle", fall_cnt - f0, 0);
      chk(rx_full == 0, "R9 nothing received", rx_full, 0);
      stop_req = 1; en = 1;
      drive_bits(16'h00_2D, 8, -1);
      wait_full(40);
      chk(rx_data == 8'h2D, "R9 realigned byte", rx_data, 8'h2D);
      idle();

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule